// File: doc/BRIEF.md
# Region-Based Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address, one request at a time. The two top address bits choose one of three mapped regions (program, control, system) or a reserved region. Each mapped region has its own table base and table length, both held in registers that software loads through a small configuration port. The walker checks the page number against the region's length, then reads the page table entry from memory over a simple read port.

The system table sits in physical memory, so a system-region walk is one read at the system base plus four times the page number. The program and control tables sit in system virtual space. Their entry address is first translated through the system table, and then the entry itself is read, so a walk takes two reads. Every walk ends with a one-cycle response that carries either a physical address and the final entry, or a fault code that names the cause.

Top module: `region_walker`

## Requirements
- R1: Address bits 31:30 select the region: 0 program, 1 control, 2 system, 3 reserved. A reserved-region request answers with fault code 2 one cycle after acceptance and makes no memory read.
- R2: A page number (bits 29:9) greater than or equal to its region's length register answers with fault code 1 one cycle after acceptance and makes no memory read.
- R3: A system-region walk makes exactly one read, at system base + 4 * page number, and answers two cycles after acceptance.
- R4: For program and control walks the entry's system virtual address is region base + 4 * page number. If its bits 31:30 are not 2, or its bits 29:9 are not below the system length, the walk answers with code 1 after one cycle. Otherwise it reads the system entry at system base + 4 * (bits 29:9), then reads the final entry at {system frame, low 9 bits}, and answers three cycles after acceptance.
- R5: The entry layout is: bit 31 valid, bits 30:27 protection, bit 26 modify, bits 25:21 for software, bits 20:0 frame. On success the fault code is 0, the physical address is {final frame, byte offset bits 8:0}, and the response also carries the final entry as read.
- R6: A clear valid bit in the nested system entry gives code 3, and the walk ends after that one read, two cycles after acceptance. A clear valid bit in the final entry gives code 4. In a system-region walk the single entry counts as the final entry.
- R7: When entry bit 27 is clear, the page is read-only. A write request to such a page gives code 5. Reads never take this fault, and only the final entry is checked.
- R8: A configuration write sets the base (select 0) or the length (select 1) of region 0, 1 or 2. A write that names region 3 changes nothing. Reset clears every base and length to zero.
- R9: The request ready signal is high only while idle. The response valid signal is a one-cycle pulse, and the response fields hold until the next response. The memory request stays high until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 3 | 0 ok, 1 length, 2 reserved, 3 system entry invalid, 4 final entry invalid, 5 protection |
| rsp_paddr | output | 30 | Physical address (zero on fault) |
| rsp_entry | output | 32 | Final entry as read (zero when no final read was made) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 2 | Region written by the configuration port |
| cfg_len_sel | input | 1 | 0 writes the base, 1 writes the length |
| cfg_wdata | input | 32 | Configuration data |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Physical byte address of the entry |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
Counted from the accepting clock edge, a length or reserved fault is due one cycle later. A system-region walk and a nested-invalid walk are due two cycles later, and a full two-level walk three cycles later, when the memory acknowledges in the same cycle. The bench's memory model acknowledges combinationally, so these latencies are exact. The bench samples every output on the falling edge and counts how many cycles pass before the response strobe, then compares that count with the figure fixed by the requirements. It also counts the acknowledged reads of each walk, so that a fault taken early must show zero reads.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int RW_VA_W    = 32;
  localparam int RW_RG_W    = 2;
  localparam int RW_OFF_W   = 9;
  localparam int RW_VPN_W   = RW_VA_W - RW_RG_W - RW_OFF_W;
  localparam int RW_FRAME_W = 21;
  localparam int RW_PA_W    = RW_FRAME_W + RW_OFF_W;
  localparam int RW_PTE_W   = 32;
  localparam int RW_NREG    = 3;
  localparam int RW_SYS_IDX = 2;
  localparam int RW_V_BIT   = 31;
  localparam int RW_WR_BIT  = 27;

  typedef enum logic [1:0] {
    RG_PROG = 2'd0,
    RG_CTRL = 2'd1,
    RG_SYS  = 2'd2,
    RG_RSVD = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_LEN     = 3'd1,
    FLT_RSVD    = 3'd2,
    FLT_SYS_INV = 3'd3,
    FLT_PTE_INV = 3'd4,
    FLT_PROT    = 3'd5
  } fault_e;

  function automatic logic [RW_VA_W-1:0] widen_vpn(input logic [RW_VPN_W-1:0] vpn);
    return {{(RW_VA_W-RW_VPN_W){1'b0}}, vpn};
  endfunction

  function automatic logic [RW_VA_W-1:0] entry_addr(input logic [RW_VA_W-1:0] base,
                                                    input logic [RW_VPN_W-1:0] vpn);
    return base + (widen_vpn(vpn) << 2);
  endfunction

  function automatic logic [RW_PA_W-1:0] make_paddr(input logic [RW_FRAME_W-1:0] frame,
                                                    input logic [RW_OFF_W-1:0] off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/rw_region_regs.sv
module rw_region_regs
  import rw_pkg::*;
#(
  parameter int NREG = RW_NREG,
  parameter int DW   = RW_VA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [RW_RG_W-1:0]        cfg_region,
  input  logic                      cfg_len_sel,
  input  logic [DW-1:0]             cfg_wdata,
  output logic [NREG-1:0][DW-1:0]   base_q,
  output logic [NREG-1:0][DW-1:0]   len_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    logic hit;
    assign hit = cfg_we && (cfg_region == RW_RG_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        len_q[g]  <= '0;
      end else if (hit) begin
        if (cfg_len_sel) len_q[g]  <= cfg_wdata;
        else             base_q[g] <= cfg_wdata;
      end
    end
  end

  // R8: a write naming the reserved region leaves every register untouched
  p_cfg_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_region == RW_RG_W'(RG_RSVD)) |=> ($stable(base_q) && $stable(len_q)));
endmodule

// File: rtl/rw_addr_check.sv
module rw_addr_check
  import rw_pkg::*;
#(
  parameter int NREG = RW_NREG
) (
  input  logic [RW_VA_W-1:0]             vaddr,
  input  logic [NREG-1:0][RW_VA_W-1:0]   base_q,
  input  logic [NREG-1:0][RW_VA_W-1:0]   len_q,
  output fault_e                         early_fault,
  output logic                           nested,
  output logic [RW_VA_W-1:0]             first_addr,
  output logic [RW_OFF_W-1:0]            pte_off
);
  localparam int VPN_LO = RW_OFF_W;
  localparam int VPN_HI = RW_OFF_W + RW_VPN_W - 1;

  logic [RW_RG_W-1:0]  rg;
  logic [RW_VPN_W-1:0] vpn;
  logic [RW_VA_W-1:0]  pte_va;
  logic [RW_VPN_W-1:0] svpn;

  assign rg  = vaddr[RW_VA_W-1 -: RW_RG_W];
  assign vpn = vaddr[VPN_HI:VPN_LO];

  always_comb begin
    early_fault = FLT_NONE;
    nested      = 1'b0;
    first_addr  = '0;
    pte_off     = '0;
    pte_va      = '0;
    svpn        = '0;
    case (region_e'(rg))
      RG_RSVD: early_fault = FLT_RSVD;
      RG_SYS: begin
        if (widen_vpn(vpn) >= len_q[RW_SYS_IDX]) early_fault = FLT_LEN;
        else first_addr = entry_addr(base_q[RW_SYS_IDX], vpn);
      end
      default: begin
        if (widen_vpn(vpn) >= len_q[rg]) begin
          early_fault = FLT_LEN;
        end else begin
          pte_va  = entry_addr(base_q[rg], vpn);
          svpn    = pte_va[VPN_HI:VPN_LO];
          pte_off = pte_va[RW_OFF_W-1:0];
          if ((pte_va[RW_VA_W-1 -: RW_RG_W] != RW_RG_W'(RG_SYS)) ||
              (widen_vpn(svpn) >= len_q[RW_SYS_IDX])) begin
            early_fault = FLT_LEN;
          end else begin
            nested     = 1'b1;
            first_addr = entry_addr(base_q[RW_SYS_IDX], svpn);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/rw_entry_eval.sv
module rw_entry_eval
  import rw_pkg::*;
(
  input  logic [RW_PTE_W-1:0]   entry,
  input  logic                  final_lvl,
  input  logic                  is_write,
  output fault_e                fault,
  output logic [RW_FRAME_W-1:0] frame
);
  assign frame = entry[RW_FRAME_W-1:0];

  always_comb begin
    if (!entry[RW_V_BIT])
      fault = final_lvl ? FLT_PTE_INV : FLT_SYS_INV;
    else if (final_lvl && is_write && !entry[RW_WR_BIT])
      fault = FLT_PROT;
    else
      fault = FLT_NONE;
  end
endmodule

// File: rtl/region_walker.sv
module region_walker
  import rw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [RW_VA_W-1:0]     req_vaddr,
  input  logic                   req_write,
  output logic                   rsp_valid,
  output logic [2:0]             rsp_fault,
  output logic [RW_PA_W-1:0]     rsp_paddr,
  output logic [RW_PTE_W-1:0]    rsp_entry,
  input  logic                   cfg_we,
  input  logic [RW_RG_W-1:0]     cfg_region,
  input  logic                   cfg_len_sel,
  input  logic [RW_VA_W-1:0]     cfg_wdata,
  output logic                   mem_req,
  output logic [RW_VA_W-1:0]     mem_addr,
  input  logic                   mem_ack,
  input  logic [RW_PTE_W-1:0]    mem_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_SYS, ST_PTE, ST_RESP} state_e;

  state_e                        state_q;
  logic [RW_NREG-1:0][RW_VA_W-1:0] base_q, len_q;
  logic [RW_VA_W-1:0]            rd_addr_q;
  logic [RW_OFF_W-1:0]           off_q, pte_off_q;
  logic                          wr_q;
  fault_e                        code_q;
  logic [RW_PA_W-1:0]            paddr_q;
  logic [RW_PTE_W-1:0]           entry_q;

  // named internal events
  fault_e                        early_fault;
  logic                          early_nested;
  logic [RW_VA_W-1:0]            early_addr;
  logic [RW_OFF_W-1:0]           early_pte_off;
  logic                          accept;
  logic                          early_hit;
  logic                          read_done;
  logic                          final_lvl;
  fault_e                        ev_fault;
  logic [RW_FRAME_W-1:0]         ev_frame;
  logic                          nested_ok;

  rw_region_regs #(.NREG(RW_NREG), .DW(RW_VA_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_region, .cfg_len_sel, .cfg_wdata,
    .base_q, .len_q
  );

  rw_addr_check #(.NREG(RW_NREG)) u_chk (
    .vaddr(req_vaddr), .base_q, .len_q,
    .early_fault, .nested(early_nested), .first_addr(early_addr), .pte_off(early_pte_off)
  );

  rw_entry_eval u_eval (
    .entry(mem_rdata), .final_lvl, .is_write(wr_q),
    .fault(ev_fault), .frame(ev_frame)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign early_hit = (early_fault != FLT_NONE);
  assign mem_req   = (state_q == ST_SYS) || (state_q == ST_PTE);
  assign mem_addr  = rd_addr_q;
  assign read_done = mem_req && mem_ack;
  assign final_lvl = (state_q == ST_PTE);
  assign nested_ok = (state_q == ST_SYS) && read_done && (ev_fault == FLT_NONE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_fault = code_q;
  assign rsp_paddr = paddr_q;
  assign rsp_entry = entry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_addr_q <= '0;
      off_q     <= '0;
      pte_off_q <= '0;
      wr_q      <= 1'b0;
      code_q    <= FLT_NONE;
      paddr_q   <= '0;
      entry_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          off_q     <= req_vaddr[RW_OFF_W-1:0];
          wr_q      <= req_write;
          rd_addr_q <= early_addr;
          pte_off_q <= early_pte_off;
          if (early_hit) begin
            code_q  <= early_fault;
            paddr_q <= '0;
            entry_q <= '0;
            state_q <= ST_RESP;
          end else begin
            state_q <= early_nested ? ST_SYS : ST_PTE;
          end
        end
        ST_SYS: if (read_done) begin
          if (ev_fault != FLT_NONE) begin
            code_q  <= ev_fault;
            paddr_q <= '0;
            entry_q <= '0;
            state_q <= ST_RESP;
          end else begin
            rd_addr_q <= {{(RW_VA_W-RW_PA_W){1'b0}}, make_paddr(ev_frame, pte_off_q)};
            state_q   <= ST_PTE;
          end
        end
        ST_PTE: if (read_done) begin
          code_q  <= ev_fault;
          paddr_q <= (ev_fault == FLT_NONE) ? make_paddr(ev_frame, off_q) : '0;
          entry_q <= mem_rdata;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1/R2: early faults answer next cycle without touching memory
  p_early_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && early_hit) |=> (rsp_valid && !mem_req));

  // R4: a valid nested entry is always followed by the final read in the same page offset
  p_nested_second_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nested_ok |=> (mem_req && mem_addr[RW_OFF_W-1:0] == $past(pte_off_q)));

  // R6: a final-level read never reports the nested-level fault
  p_level_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && final_lvl) |=> (rsp_valid && rsp_fault != 3'(FLT_SYS_INV)));

  // R7: protection faults only come from write requests
  p_prot_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'(FLT_PROT)) |-> wr_q);

  // R9: response is a single-cycle pulse and the walker is busy while reading
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  p_busy_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

// File: tb/region_walker_test.sv
`timescale 1ns/1ps
module region_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [29:0] rsp_paddr;
  logic [31:0] rsp_entry;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_region = '0;
  logic        cfg_len_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int tests = 0;
  int fails = 0;
  int rd_cnt = 0;
  logic [31:0] tb_base [3];
  logic [31:0] tb_len  [3];

  localparam logic [31:0] SYS_TBL = 32'h0001_0000;

  always #10 clk = ~clk;

  region_walker uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_write,
    .rsp_valid, .rsp_fault, .rsp_paddr, .rsp_entry,
    .cfg_we, .cfg_region, .cfg_len_sel, .cfg_wdata,
    .mem_req, .mem_addr, .mem_ack, .mem_rdata
  );

  // memory model: system table entries near SYS_TBL, computed entries elsewhere
  function automatic logic [31:0] mem_model(input logic [31:0] a);
    logic [31:0] s;
    if (a >= SYS_TBL && a < SYS_TBL + 32'd256) begin
      s = (a - SYS_TBL) >> 2;
      return {(s != 32'd5), 3'b000, ~s[0], 1'b0, 5'd0, 21'h100 + s[20:0]};
    end
    return {(a[6:2] != 5'd7), 3'b010, a[2], 1'b1, 5'h11, a[22:2] + 21'd3};
  endfunction

  assign mem_ack   = mem_req;
  assign mem_rdata = mem_model(mem_addr);

  always @(posedge clk) if (mem_req && mem_ack) rd_cnt <= rd_cnt + 1;

  // expected walk result for a successful translation, from the requirements
  function automatic logic [61:0] model_ok(input logic [31:0] va);
    logic [31:0] e, e1, pva;
    logic [29:0] pa;
    if (va[31:30] == 2'd2) begin
      e = mem_model(tb_base[2] + {9'd0, va[29:9], 2'b00});
    end else begin
      pva = tb_base[va[31:30]] + {9'd0, va[29:9], 2'b00};
      e1  = mem_model(tb_base[2] + {9'd0, pva[29:9], 2'b00});
      pa  = {e1[20:0], pva[8:0]};
      e   = mem_model({2'b00, pa});
    end
    return {e[20:0], va[8:0], e};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] rg, input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_region = rg; cfg_len_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (rg != 2'd3) begin
      if (sel) tb_len[rg] = d; else tb_base[rg] = d;
    end
  endtask

  task automatic walk(input string tag, input logic [31:0] va, input logic wr,
                      input logic [2:0] code);
    int lat, start, exp_rd;
    logic [61:0] m;
    @(negedge clk);
    check({tag, " R9 ready idle"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    start = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (code == 3'd1 || code == 3'd2) exp_rd = 0;
    else if (va[31:30] == 2'd2 || code == 3'd3) exp_rd = 1;
    else exp_rd = 2;
    if (exp_rd > 0) check({tag, " R9 busy not ready"}, 64'(req_ready), 64'd0);
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check({tag, " R1 R2 R3 R4 latency"}, 64'(lat), 64'(exp_rd + 1));
    check({tag, " R2 R4 R6 read count"}, 64'(rd_cnt - start), 64'(exp_rd));
    check({tag, " R5 R6 R7 fault code"}, 64'(rsp_fault), 64'(code));
    if (code == 3'd0) begin
      m = model_ok(va);
      check({tag, " R5 paddr"}, 64'(rsp_paddr), 64'(m[61:32]));
      check({tag, " R5 entry"}, 64'(rsp_entry), 64'(m[31:0]));
    end else begin
      check({tag, " R5 paddr zero on fault"}, 64'(rsp_paddr), 64'd0);
    end
    @(negedge clk);
    check({tag, " R9 pulse"}, 64'(rsp_valid), 64'd0);
    check({tag, " R9 hold"}, 64'(rsp_fault), 64'(code));
  endtask

  // vectors: {vaddr, write, expected fault code}
  localparam int NV = 17;
  localparam logic [35:0] VECS [NV] = '{
    {32'h8000_07AB, 1'b0, 3'd0},  // R3 system read
    {32'h8000_0600, 1'b1, 3'd5},  // R7 system write read-only
    {32'h8000_08FF, 1'b1, 3'd0},  // R7 system write allowed
    {32'h8000_0A04, 1'b0, 3'd4},  // R6 system entry invalid (final level)
    {32'h8000_8000, 1'b0, 3'd1},  // R2 system vpn == length
    {32'hC000_1234, 1'b0, 3'd2},  // R1 reserved
    {32'hFFFF_FFFF, 1'b1, 3'd2},  // R1 reserved write
    {32'h0000_0010, 1'b0, 3'd0},  // R4 program read
    {32'h0000_0010, 1'b1, 3'd5},  // R7 program write read-only
    {32'h0000_0321, 1'b1, 3'd0},  // R7 program write allowed
    {32'h0000_0E00, 1'b0, 3'd4},  // R6 final entry invalid
    {32'h0003_0000, 1'b0, 3'd3},  // R6 nested entry invalid
    {32'h0003_1E00, 1'b0, 3'd3},  // R2 last page below length
    {32'h0003_2000, 1'b0, 3'd1},  // R2 program vpn == length
    {32'h4000_0455, 1'b0, 3'd0},  // R4 control read
    {32'h4000_0455, 1'b1, 3'd5},  // R7 control write read-only
    {32'h4000_2000, 1'b0, 3'd1}   // R2 control vpn == length
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin tb_base[i] = '0; tb_len[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R9 reset mem_req", 64'(mem_req), 64'd0);
    check("R9 reset ready", 64'(req_ready), 64'd1);
    // R8: zero lengths after reset make every mapped access a length fault
    walk("R8 reset sys", 32'h8000_0000, 1'b0, 3'd1);
    walk("R8 reset prog", 32'h0000_0000, 1'b0, 3'd1);

    cfg_write(2'd2, 1'b0, SYS_TBL);
    cfg_write(2'd2, 1'b1, 32'd64);
    cfg_write(2'd0, 1'b0, 32'h8000_0400);
    cfg_write(2'd0, 1'b1, 32'd400);
    cfg_write(2'd1, 1'b0, 32'h8000_1000);
    cfg_write(2'd1, 1'b1, 32'd16);

    for (int v = 0; v < NV; v++)
      walk($sformatf("vec%0d", v), VECS[v][35:4], VECS[v][3], VECS[v][2:0]);

    // R4: nested index at the system length bound
    cfg_write(2'd2, 1'b1, 32'd8);
    walk("R4 nested length", 32'h4000_0455, 1'b0, 3'd1);
    cfg_write(2'd2, 1'b1, 32'd9);
    walk("R4 nested last entry", 32'h4000_0455, 1'b0, 3'd0);
    cfg_write(2'd2, 1'b1, 32'd64);
    // R4: table address outside system space
    cfg_write(2'd1, 1'b0, 32'h0000_1000);
    walk("R4 table not in system space", 32'h4000_0455, 1'b0, 3'd1);
    cfg_write(2'd1, 1'b0, 32'h8000_1000);

    // R8: writes naming region 3 do not alter any mapped region
    cfg_write(2'd3, 1'b1, 32'd0);
    cfg_write(2'd3, 1'b0, 32'h0000_0000);
    walk("R8 region3 ignored sys", 32'h8000_07AB, 1'b0, 3'd0);
    walk("R8 region3 ignored ctrl", 32'h4000_0455, 1'b0, 3'd0);
    walk("R8 region3 ignored prog", 32'h0000_0321, 1'b1, 3'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule